// File: doc/BRIEF.md
# Oscillator Band Search Sequencer

This block picks one of eight overlapping oscillator bands with a three-bit binary search. A search starts on its own shortly after reset and again whenever the `start` input pulses. Software or the register front end pulses `start` each time the feedback divider setting is rewritten. The search is paced by the reference-divider output pulse `ref_tick`, slowed down by a selectable factor of 1, 2, 4 or 8. This keeps the search rate low when the phase detector runs fast.

While a search runs, `tune_park` is high. It tells the analog side to detach the tuning node from the loop filter and hold it at an internal reference. The analog side also supplies `too_fast`, which is high when the oscillator at the current trial band runs above target.

A search has five paced steps:
- Step one puts the mid code on `band` and lets the loop settle.
- Steps two to four each decide one band bit, from the most significant bit down.
- Step five releases the park and gives a one-clock `done` pulse.

The loop then resumes normal operation on the chosen band.

Top module: `vbs_band_seq`

## Requirements
- R1: While `rst_n` is low, `band` is 3'b100 and `busy`, `tune_park` and `done` are all 0.
- R2: With no `start` pulse, a search begins by itself on the third rising clock edge after `rst_n` goes high. After that edge `busy` and `tune_park` are 1 and `band` is 3'b100.
- R3: A `start` pulse seen at a rising edge begins a search at that edge. After the edge `busy` is 1 and `band` is 3'b100.
- R4: `pre_sel` sets D, the number of `ref_tick` pulses per step: 0 gives D=1, 1 gives D=2, 2 gives D=4 and 3 gives D=8. A search ends at the edge of the 5·D-th `ref_tick` after its start edge. A `ref_tick` in the start cycle itself does not count.
- R5: At the end of step two, band bit 2 is cleared if `too_fast` is 1 in that cycle, and bit 1 is set. At the end of step three, bit 1 is decided the same way and bit 0 is set. At the end of step four, bit 0 is decided. With a monotonic comparator the final code equals the target band.
- R6: `tune_park` is 1 exactly while `busy` is 1, and both drop at the edge that ends the search.
- R7: `done` is 1 for exactly one clock, in the cycle right after the ending edge, together with `busy` falling.
- R8: A `start` pulse during a search restarts it from step one. The band returns to 3'b100, and a full five steps follow with no `done` in between.
- R9: `pre_sel` is sampled only at a start edge. Changing it during a search does not alter the step length.
- R10: When `start` and the final step's `ref_tick` fall in the same cycle, the restart wins. No `done` is issued, `band` returns to 3'b100, and `busy` stays 1.
- R11: When idle, `band` holds the committed code, and `ref_tick` and `too_fast` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-clock pulse from the reference divider |
| pre_sel | input | 2 | Step prescale select (1, 2, 4, 8 ticks per step) |
| start | input | 1 | One-clock request to begin or restart a search |
| too_fast | input | 1 | Comparator: oscillator above target at current band |
| band | output | 3 | Trial or committed band code |
| tune_park | output | 1 | High: tuning node held at internal reference |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-clock pulse when the band is committed |

## Verification
Two functions can fall in the same cycle: the commit at the last step and a fresh restart request. The bench drives `start` and the final `ref_tick` in the same clock. It then judges that no `done` appears, that the band is back at the mid code, and that exactly five more full steps pass before the next commit. Pacing is checked at every tick for all four prescale settings, including a `pre_sel` change in mid-search, and the search result is checked for every one of the eight target bands.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_SEARCH = 2'd2,
    PH_COMMIT = 2'd3
  } phase_e;

endpackage

// File: rtl/vbs_prescale.sv
module vbs_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             ref_tick,
  output logic             step_tick
);

  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, wrap;

  // terminal count = 2^sel - 1, built as a thermometer of ones
  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      wrap[i] = (i < int'(sel_q));
    end
  end

  assign step_tick = ref_tick && (cnt_q == wrap);

  always_comb begin
    cnt_d = cnt_q;
    if (go) begin
      cnt_d = '0;
    end else if (ref_tick) begin
      cnt_d = step_tick ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      if (go) begin
        sel_q <= sel_in;
      end
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/vbs_sar_fsm.sv
module vbs_sar_fsm
  import vbs_pkg::*;
#(
  parameter int BAND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              step_tick,
  input  logic              too_fast,
  output logic [BAND_W-1:0] band,
  output logic              park,
  output logic              busy,
  output logic              done
);

  localparam int IDX_W = (BAND_W > 1) ? $clog2(BAND_W) : 1;
  localparam logic [BAND_W-1:0] MID_CODE = BAND_W'(1 << (BAND_W - 1));
  localparam logic [IDX_W-1:0]  TOP_IDX  = IDX_W'(BAND_W - 1);

  phase_e            phase_q, phase_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BAND_W-1:0] band_q, band_d;
  logic              park_q, park_d;
  logic              done_q, done_d;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    band_d  = band_q;
    park_d  = park_q;
    done_d  = 1'b0;
    if (go) begin
      phase_d = PH_SETTLE;
      idx_d   = TOP_IDX;
      band_d  = MID_CODE;
      park_d  = 1'b1;
    end else if (step_tick) begin
      case (phase_q)
        PH_SETTLE: phase_d = PH_SEARCH;
        PH_SEARCH: begin
          if (too_fast) begin
            band_d[idx_q] = 1'b0;
          end
          if (idx_q == '0) begin
            phase_d = PH_COMMIT;
          end else begin
            band_d[idx_q - 1'b1] = 1'b1;
            idx_d = idx_q - 1'b1;
          end
        end
        PH_COMMIT: begin
          phase_d = PH_IDLE;
          park_d  = 1'b0;
          done_d  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= TOP_IDX;
      band_q  <= MID_CODE;
      park_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      band_q  <= band_d;
      park_q  <= park_d;
      done_q  <= done_d;
    end
  end

  assign band = band_q;
  assign park = park_q;
  assign busy = (phase_q != PH_IDLE);
  assign done = done_q;

endmodule

// File: rtl/vbs_band_seq.sv
module vbs_band_seq #(
  parameter int BAND_W = 3,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [SEL_W-1:0]  pre_sel,
  input  logic              start,
  input  logic              too_fast,
  output logic [BAND_W-1:0] band,
  output logic              tune_park,
  output logic              busy,
  output logic              done
);

  logic [1:0] rsync_q;
  logic       rst_core_n;
  logic       boot_q;
  logic       go;
  logic       step_tick;

  // reset asserts at once, leaves on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rsync_q[1];

  // power-up request: one cycle after internal reset leaves
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      boot_q <= 1'b1;
    end else begin
      boot_q <= 1'b0;
    end
  end

  assign go = start | boot_q;

  vbs_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .go        (go),
    .sel_in    (pre_sel),
    .ref_tick  (ref_tick),
    .step_tick (step_tick)
  );

  vbs_sar_fsm #(.BAND_W(BAND_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .go        (go),
    .step_tick (step_tick),
    .too_fast  (too_fast),
    .band      (band),
    .park      (tune_park),
    .busy      (busy),
    .done      (done)
  );

endmodule

// File: rtl/vbs_band_seq_chk.sv
module vbs_band_seq_chk #(
  parameter int BAND_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [BAND_W-1:0] band,
  input logic              park,
  input logic              busy,
  input logic              done
);

  localparam logic [BAND_W-1:0] MID_CODE = BAND_W'(1 << (BAND_W - 1));

  p_start_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && band == MID_CODE))
    else $error("start did not load mid code");

  p_park_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    park == busy)
    else $error("park and busy disagree");

  p_done_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)))
    else $error("done without busy falling");

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one clock");

  p_restart_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done)
    else $error("done issued despite restart");

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(band))
    else $error("band moved while idle");

endmodule

bind vbs_band_seq vbs_band_seq_chk #(.BAND_W(BAND_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_core_n),
  .start (start),
  .band  (band),
  .park  (tune_park),
  .busy  (busy),
  .done  (done)
);

// File: tb/vbs_band_seq_bench.sv
module vbs_band_seq_bench;

  logic       clk;
  logic       rst_n;
  logic       ref_tick;
  logic [1:0] pre_sel;
  logic       start;
  logic       too_fast;
  logic [2:0] band;
  logic       tune_park;
  logic       busy;
  logic       done;

  logic [2:0] tgt;
  logic       ovr_en;
  logic       ovr_val;

  int checks;
  int errors;

  vbs_band_seq u_vbs_band_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .pre_sel   (pre_sel),
    .start     (start),
    .too_fast  (too_fast),
    .band      (band),
    .tune_park (tune_park),
    .busy      (busy),
    .done      (done)
  );

  // monotonic comparator model: too fast when trial band exceeds target
  assign too_fast = ovr_en ? ovr_val : (band > tgt);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_ref();
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  // run the remaining five steps of a search just started; d ticks per step
  task automatic drive_steps(input int d);
    for (int i = 1; i <= 5 * d; i++) begin
      pulse_ref();
      chk("R6 park follows busy", int'(tune_park), int'(busy));
      if (i < 5 * d) begin
        chk("R4 still busy", int'(busy), 1);
        chk("R7 no early done", int'(done), 0);
      end
      if (i == 2 * d) chk("R5 after bit2", int'(band), int'({tgt[2], 2'b10}));
      if (i == 3 * d) chk("R5 after bit1", int'(band), int'({tgt[2:1], 1'b1}));
      if (i == 5 * d) begin
        chk("R4 ends on last tick", int'(busy), 0);
        chk("R7 done pulse", int'(done), 1);
        chk("R5 final band", int'(band), int'(tgt));
        chk("R6 park released", int'(tune_park), 0);
      end
      if (i % 3 == 0) @(negedge clk);
    end
    @(negedge clk);
    chk("R7 done one clock", int'(done), 0);
    chk("R11 band held", int'(band), int'(tgt));
  endtask

  task automatic t_reset_boot();
    rst_n = 1'b0;
    tgt = 3'd5;
    repeat (3) @(negedge clk);
    chk("R1 band", int'(band), 4);
    chk("R1 busy", int'(busy), 0);
    chk("R1 park", int'(tune_park), 0);
    chk("R1 done", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 idle before boot", int'(busy), 0);
    @(negedge clk);
    chk("R2 boot busy", int'(busy), 1);
    chk("R2 boot park", int'(tune_park), 1);
    chk("R2 boot band", int'(band), 4);
    drive_steps(1);
  endtask

  task automatic run_seq(input logic [2:0] t, input logic [1:0] sel, input bit chg);
    tgt = t;
    start = 1'b1;
    pre_sel = sel;
    @(negedge clk);
    start = 1'b0;
    if (chg) pre_sel = ~sel; // R9: must not alter step length
    chk("R3 busy", int'(busy), 1);
    chk("R3 band mid", int'(band), 4);
    drive_steps(1 << sel);
  endtask

  task automatic t_idle();
    logic [2:0] held;
    held = band;
    ovr_en = 1'b1;
    ovr_val = 1'b1;
    for (int i = 0; i < 6; i++) begin
      ovr_val = i[0];
      pulse_ref();
      chk("R11 band idle", int'(band), int'(held));
      chk("R11 busy idle", int'(busy), 0);
      chk("R11 done idle", int'(done), 0);
    end
    ovr_en = 1'b0;
  endtask

  task automatic t_restart();
    tgt = 3'd2;
    start = 1'b1;
    pre_sel = 2'd0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3; i++) pulse_ref();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 restart busy", int'(busy), 1);
    chk("R8 restart band", int'(band), 4);
    drive_steps(1);
  endtask

  task automatic t_collide();
    tgt = 3'd6;
    start = 1'b1;
    pre_sel = 2'd1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 9; i++) pulse_ref();
    start = 1'b1;
    ref_tick = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ref_tick = 1'b0;
    chk("R10 restart wins busy", int'(busy), 1);
    chk("R10 no done", int'(done), 0);
    chk("R10 band mid", int'(band), 4);
    @(negedge clk);
    chk("R10 no late done", int'(done), 0);
    drive_steps(2);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    ref_tick = 1'b0;
    start = 1'b0;
    pre_sel = 2'd0;
    ovr_en = 1'b0;
    ovr_val = 1'b0;
    tgt = 3'd0;
    rst_n = 1'b0;
    @(negedge clk);
    t_reset_boot();
    for (int k = 0; k < 8; k++) begin
      run_seq(3'(k), 2'(k % 4), k[0]);
    end
    run_seq(3'd1, 2'd3, 1'b1);
    t_idle();
    t_restart();
    t_collide();
    summary();
    $finish;
  end

endmodule